// File: doc/BRIEF.md
# SPI SD-Card Host Controller

This block is an SPI master for an SD card running in SPI mode. Software reaches it through one 32-bit register. A read returns status flags and the byte at the head of a receive queue. A write can push a transmit byte, pop a received byte, load the SCK divider and update the control flags, and a single write may do several of these at once. The shift engine runs in SPI mode 0 and sends the most significant bit first. Chip select is active while the transceiver is enabled. When no transmit byte is queued, the engine sends 0xFF filler so that the card's response can be clocked in.

A self-clearing receive filter discards the idle 0xFF bytes that come before a card response. A forced-clock mode toggles SCK with chip select inactive, which gives the card its power-up clock cycles. The register also reports card detect, card changed and card busy.

Top module: `sd_spi_host`

## Requirements
- R1: After reset, chip select (`cs_no`) is high and SCK is low. The register reads 0x0000_0C00: transmitter ready (bit 11) and transmit queue empty (bit 10) are set, and every other bit is zero, given card detect low and MISO high.
- R2: A write with bit 8 set queues bits 7:0 for transmission. Queued bytes go out on MOSI in order, MSB first: MOSI changes after SCK falls and is stable on the SCK rising edge. Bit 10 reads 1 only when the 4-entry transmit queue is empty. Bit 11 reads 0 when the queue is full, and a byte written while it is full is dropped.
- R3: A write with bits 14 and 12 set enables the transceiver. `cs_no` is low exactly while the transceiver is enabled. With the transmit queue empty, the engine sends 0xFF filler bytes.
- R4: MISO is sampled on each SCK rising edge. A completed byte enters a 4-entry receive queue. Bit 9 shows that the queue is not empty, and bits 7:0 show its head (zero when empty). Reading the register never pops the queue. A write with bit 9 set pops one byte, and this can happen in the same write as a transmit push.
- R5: Bit 13 in a control write enables the receive filter. While the filter is on, received 0xFF bytes are discarded. The first byte that is not 0xFF is stored and switches the filter off.
- R6: A byte that completes while the receive queue is full is dropped and sets bit 8 (overrun). Any control write clears bit 8.
- R7: A write with bit 10 set loads bits 7:0 as divider D. Each SCK half-period then lasts D+1 clock cycles.
- R8: Bit 11 in a control write, with the transceiver disabled, makes SCK toggle continuously with `cs_no` high. No byte is sent or received in this mode.
- R9: The filter, transceiver and force-clock bits (13, 12, 11) have no effect unless bit 14 is also set in the same write.
- R10: Bit 14 gives the synchronized card-detect input. Bit 13 (card changed) is set by any edge of that input and cleared by a control write.
- R11: Bit 12 (card busy) reads 1 while MISO is held low with the engine not shifting.
- R12: Bits 31:15 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| card_det_i | input | 1 | Card detect, asynchronous |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to card |
| miso_i | input | 1 | SPI data from card |
| cs_no | output | 1 | Chip select, active low |

## Verification
One register write can pop the receive queue and push the transmit queue in the same cycle. The bench provokes this with a write that sets bits 9 and 8 together after an overrun has filled the receive queue. It judges the pop by counting how many further acknowledges it takes before bit 9 drops, and the push by bit 10 falling. The bench also lets the filter's self-clearing land on the byte that follows the first non-0xFF response. A 0xFF that is stored after 0x12 and 0x34 shows that the filter turned itself off.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

  // write fields
  localparam int W_CTRL  = 14;
  localparam int W_FILT  = 13;
  localparam int W_XCVR  = 12;
  localparam int W_FORCE = 11;
  localparam int W_DIV   = 10;
  localparam int W_ACK   = 9;
  localparam int W_DATA  = 8;

  typedef struct packed {
    logic filt;
    logic xcvr;
    logic force_clk;
  } ctrl_t;

  typedef struct packed {
    logic              det;
    logic              changed;
    logic              busy;
    logic              tx_rdy;
    logic              tx_empty;
    logic              rx_avail;
    logic              overrun;
    logic [BYTE_W-1:0] head;
  } status_t;
endpackage

// File: rtl/sd_spi_fifo.sv
module sd_spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign full_o  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty_o = (wp == rp);
  assign data_o  = mem[rp[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_i) wp <= wp + 1'b1;
      if (pop_i)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp[AW-1:0]] <= data_i;
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sd_spi_engine.sv
module sd_spi_engine
  import sd_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xcvr_i,
  input  logic              force_i,
  input  logic [BYTE_W-1:0] div_i,
  input  logic              tx_avail_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              tx_pop_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              idle_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int BW = $clog2(BYTE_W);

  logic              shifting;
  logic [BW-1:0]     bitn;
  logic [BYTE_W-1:0] tx_sr, rx_sr, cnt;
  logic              run, tick;

  assign run      = xcvr_i ? shifting : force_i;
  assign tick     = run && (cnt >= div_i);
  assign tx_pop_o = xcvr_i && !shifting && tx_avail_i;
  assign idle_o   = !shifting;
  assign mosi_o   = shifting ? tx_sr[BYTE_W-1] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt <= '0;
    else if (tick || !run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shifting   <= 1'b0;
      bitn       <= '0;
      tx_sr      <= IDLE_BYTE;
      rx_sr      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      sck_o      <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!xcvr_i) begin
        shifting <= 1'b0;
        if (!force_i)  sck_o <= 1'b0;
        else if (tick) sck_o <= ~sck_o;
      end else if (!shifting) begin
        shifting <= 1'b1;
        bitn     <= '0;
        sck_o    <= 1'b0;
        tx_sr    <= tx_avail_i ? tx_byte_i : IDLE_BYTE;
      end else if (tick) begin
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_sr <= {rx_sr[BYTE_W-2:0], miso_i};
        end else begin
          sck_o <= 1'b0;
          if (bitn == BW'(BYTE_W-1)) begin
            shifting   <= 1'b0;
            rx_valid_o <= 1'b1;
            rx_byte_o  <= rx_sr;
          end else begin
            bitn  <= bitn + 1'b1;
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b1};
          end
        end
      end
    end
  end

  a_r3_no_rx_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xcvr_i |=> !rx_valid_o);
  a_r7_sck_holds_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick) |=> $stable(sck_o));
  a_r2_mosi_stable_high_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcvr_i && shifting && !sck_o && tick) |=> $stable(mosi_o));
endmodule

// File: rtl/sd_spi_host.sv
module sd_spi_host
  import sd_spi_pkg::*;
#(
  parameter int              TX_DEPTH = 4,
  parameter int              RX_DEPTH = 4,
  parameter logic [7:0]      DIV_RST  = 8'd3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        card_det_i,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no
);
  localparam int STAT_W = $bits(status_t);

  ctrl_t             ctrl;
  logic [BYTE_W-1:0] div_q;
  logic              ovr_q, chg_q, busy_q, busy_s;
  logic [2:0]        det_s;

  logic              cw, tx_push, rx_pop, rx_keep, rx_push, det_edge;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_pop, rx_valid, eng_idle;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  status_t           st;

  assign cw       = wr_en_i && wdata_i[W_CTRL];
  assign tx_push  = wr_en_i && wdata_i[W_DATA] && !tx_full;
  assign rx_pop   = wr_en_i && wdata_i[W_ACK] && !rx_empty;
  assign rx_keep  = rx_valid && !(ctrl.filt && rx_byte == IDLE_BYTE);
  assign rx_push  = rx_keep && !rx_full;
  assign det_edge = det_s[1] ^ det_s[2];
  assign cs_no    = !ctrl.xcvr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl  <= '0;
      div_q <= DIV_RST;
      ovr_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      if (wr_en_i && wdata_i[W_DIV]) div_q <= wdata_i[BYTE_W-1:0];
      if (cw) begin
        ctrl  <= '{filt: wdata_i[W_FILT], xcvr: wdata_i[W_XCVR],
                   force_clk: wdata_i[W_FORCE]};
        ovr_q <= 1'b0;
        chg_q <= 1'b0;
      end else begin
        if (rx_valid && ctrl.filt && rx_byte != IDLE_BYTE) ctrl.filt <= 1'b0;
        if (rx_keep && rx_full) ovr_q <= 1'b1;
        if (det_edge) chg_q <= 1'b1;
      end
    end
  end

  // card detect sync and busy sampling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_s  <= '0;
      busy_s <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      det_s  <= {det_s[1:0], card_det_i};
      busy_s <= ~miso_i;
      if (eng_idle) busy_q <= busy_s;
    end
  end

  sd_spi_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push), .data_i (wdata_i[BYTE_W-1:0]),
    .pop_i  (tx_pop),  .data_o (tx_head),
    .full_o (tx_full), .empty_o(tx_empty)
  );

  sd_spi_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push), .data_i (rx_byte),
    .pop_i  (rx_pop),  .data_o (rx_head),
    .full_o (rx_full), .empty_o(rx_empty)
  );

  sd_spi_engine u_engine (
    .clk_i, .rst_ni,
    .xcvr_i     (ctrl.xcvr),
    .force_i    (ctrl.force_clk),
    .div_i      (div_q),
    .tx_avail_i (!tx_empty),
    .tx_byte_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .rx_valid_o (rx_valid),
    .rx_byte_o  (rx_byte),
    .idle_o     (eng_idle),
    .sck_o, .mosi_o, .miso_i
  );

  always_comb begin
    st.det      = det_s[1];
    st.changed  = chg_q;
    st.busy     = busy_q;
    st.tx_rdy   = !tx_full;
    st.tx_empty = tx_empty;
    st.rx_avail = !rx_empty;
    st.overrun  = ovr_q;
    st.head     = rx_empty ? '0 : rx_head;
    rdata_o     = {{(32-STAT_W){1'b0}}, st};
  end

  a_r6_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_keep && rx_full && !cw) |=> rdata_o[8]);
  a_r6_overrun_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw |=> !rdata_o[8]);
  a_r5_filter_self_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && ctrl.filt && rx_byte != IDLE_BYTE && !cw) |=> !ctrl.filt);
  a_r5_filter_drops_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && ctrl.filt && rx_byte == IDLE_BYTE) |-> !rx_push);
  a_r10_change_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_edge && !cw) |=> rdata_o[13]);
  a_r3_cs_follows_xcvr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw && wdata_i[W_XCVR]) |=> !cs_no);
  a_r9_no_ctrl_without_cw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdata_i[W_CTRL]) |=> $stable(cs_no));
endmodule

// File: tb/sd_spi_host_test.sv
module sd_spi_host_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        card_det = 1'b0;
  logic        sck, mosi, miso, cs_n;
  logic        miso_low = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  localparam logic [31:0] CW = 32'h4000, FILT = 32'h2000, XCVR = 32'h1000,
                          FORCE = 32'h0800, DIVW = 32'h0400, ACK = 32'h0200,
                          DW = 32'h0100;

  sd_spi_host uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .card_det_i(card_det), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  always #2.5 clk = ~clk;

  // SD card model
  logic [7:0] resp [16];
  int         nresp = 0;
  int         bitc = 0, frame = 0;
  logic [7:0] sh_in = '0;
  logic [7:0] mosi_log [32];
  logic [7:0] cur;
  int         sck_rises = 0;

  always_comb begin
    cur = (frame < nresp && frame < 16) ? resp[frame] : 8'hFF;
    if (miso_low)  miso = 1'b0;
    else if (cs_n) miso = 1'b1;
    else           miso = cur[7-bitc];
  end

  always @(posedge sck) begin
    sck_rises = sck_rises + 1;
    if (!cs_n) sh_in = {sh_in[6:0], mosi};
  end

  always @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      bitc = 0; frame = 0;
    end else if (bitc == 7) begin
      if (frame < 32) mosi_log[frame] = sh_in;
      frame = frame + 1;
      bitc = 0;
    end else bitc = bitc + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ra();
    for (int i = 0; i < 3000 && !rdata[9]; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1, R12
    chk("R1 reset status", rdata, 32'h0000_0C00);
    chk("R1 cs/sck idle", {cs_n, sck}, 2'b10);
    chk("R12 upper bits zero", rdata[31:15], 17'h0);

    // R2 transmit queue flags
    wr(DIVW | 32'd1);
    wr(DW | 32'hA5); wr(DW | 32'h3C); wr(DW | 32'h00);
    chk("R2 te clear, tr set", rdata[11:10], 2'b10);
    wr(DW | 32'h81);
    chk("R2 full clears tr", rdata[11:10], 2'b00);
    wr(DW | 32'h77); // dropped, queue full

    // R9 control bits without CW ignored
    sck_rises = 0;
    wr(FILT | XCVR | FORCE);
    idle(40);
    chk("R9 cs stays high", cs_n, 1'b1);
    chk("R9 no sck activity", sck_rises, 0);

    // R3/R4/R5 response with filter
    resp[0] = 8'hFF; resp[1] = 8'hFF; resp[2] = 8'hFF; resp[3] = 8'hFF;
    resp[4] = 8'hFF; resp[5] = 8'h12; resp[6] = 8'h34; resp[7] = 8'hFF;
    nresp = 8;
    wr(CW | XCVR | FILT);
    chk("R3 cs low when enabled", cs_n, 1'b0);
    wait_ra();
    chk("R5 first kept byte", rdata[9:0], 10'h212);
    idle(3);
    chk("R4 read does not pop", rdata[7:0], 8'h12);
    wr(ACK);
    wait_ra();
    chk("R4 ack pops to next", rdata[7:0], 8'h34);
    wr(ACK);
    wait_ra();
    chk("R5 filter self-cleared, 0xFF kept", rdata[7:0], 8'hFF);
    wr(CW);
    chk("R3 cs high when disabled", cs_n, 1'b1);
    chk("R2 byte0 MSB first", mosi_log[0], 8'hA5);
    chk("R2 byte1", mosi_log[1], 8'h3C);
    chk("R2 byte2", mosi_log[2], 8'h00);
    chk("R2 byte3", mosi_log[3], 8'h81);
    chk("R3 filler after queue (R2 full drop)", mosi_log[4], 8'hFF);
    chk("R2 te after drain", rdata[10], 1'b1);
    for (int i = 0; i < 8 && rdata[9]; i++) wr(ACK);
    chk("R4 empty head reads zero", rdata[9:0], 10'h000);
    nresp = 0;

    // R6 overrun, then combined push/pop
    wr(DIVW | 32'd0);
    wr(CW | XCVR);
    idle(200);
    wr(CW);
    chk("R6 overrun cleared by control write", rdata[9:8], 2'b10);
    wr(CW | XCVR);
    idle(200);
    chk("R6 overrun set when full", rdata[9:8], 2'b11);
    wr(CW);
    chk("R6 cleared, data kept", rdata[9:8], 2'b10);
    wr(DW | ACK | 32'h5A);
    chk("R4 combined write pushed tx", rdata[10], 1'b0);
    wr(ACK);
    wr(ACK);
    chk("R4 one byte left after 3 pops", rdata[9], 1'b1);
    wr(ACK);
    chk("R4 depth 4 consumed by combined pop", rdata[9], 1'b0);

    // R7/R8 divider sweep in forced-clock mode
    for (int d = 0; d < 4; d++) begin
      int t1, t2;
      wr(DIVW | 32'(d));
      wr(CW | FORCE);
      @(posedge sck); t1 = cyc;
      @(posedge sck); t2 = cyc;
      chk($sformatf("R7 sck period div=%0d", d), t2 - t1, 2 * (d + 1));
      @(negedge clk);
      chk("R8 cs high in forced clock", cs_n, 1'b1);
      idle(20);
      wr(CW);
      chk("R8 no data moved (te=0, ra=0)", rdata[10:9], 2'b00);
    end

    // R10 card detect
    card_det = 1'b1;
    idle(4);
    chk("R10 detect and changed", rdata[14:13], 2'b11);
    wr(CW);
    chk("R10 changed cleared", rdata[14:13], 2'b10);
    card_det = 1'b0;
    idle(4);
    chk("R10 removal edge", rdata[14:13], 2'b01);
    wr(CW);

    // R11 busy
    miso_low = 1'b1;
    idle(4);
    chk("R11 busy while miso low", rdata[12], 1'b1);
    miso_low = 1'b0;
    idle(4);
    chk("R11 busy released", rdata[12], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule